// File: doc/BRIEF.md
# Shifter Operand Barrel Unit

This block forms the second operand that a 32-bit load-store datapath hands to its ALU. It has two sources. In immediate mode, an 8-bit unsigned constant is zero-extended to the data width. In register mode, a register value passes through a barrel shifter. The shifter takes one of five shift kinds, and the shift distance comes either from a small immediate field or from the low byte of a second register. Besides the operand, the block returns a shifter carry. That carry is the last bit pushed out of the register, and it feeds the carry flag of logical and move operations.

The datapath drives the mode and shift controls that the decoder extracts from the instruction. It also drives the register value and the current carry flag. The block is combinational by default. A parameter adds one output register stage for pipelines that need the operand on a flop boundary. Instruction decode, the register file and the ALU are outside the block.

Top module: `operand_shifter`

## Requirements
- R1: With `use_imm`=1, `operand_out` equals `imm_val` zero-extended to DATA_W bits and `carry_out` equals `carry_in`, whatever the register value, shift kind and amounts are.
- R2: With `amt_from_reg`=0 the shift distance is the 5-bit `amt_imm` (0..31) and `amt_reg` is ignored; with `amt_from_reg`=1 the distance is the full 8-bit `amt_reg` (0..255) and `amt_imm` is ignored.
- R3: For shift kinds 0..3 a distance of zero returns `rm_val` unchanged with `carry_out` = `carry_in`.
- R4: Kind 0 (logical left) by n in 1..31 gives rm<<n with carry rm[32-n]; by 32 gives 0 with carry rm[0]; above 32 gives 0 with carry 0 (e.g. 0x80000004 by 1 gives 0x00000008 with carry 1, and a shift by 3 multiplies by 8).
- R5: Kind 1 (logical right) by n in 1..31 gives rm>>n with carry rm[n-1]; by 32 gives 0 with carry rm[31]; above 32 gives 0 with carry 0.
- R6: Kind 2 (arithmetic right) by n in 1..31 shifts in copies of rm[31] with carry rm[n-1]; by 32 or more every bit and the carry equal rm[31].
- R7: Kind 3 (rotate right) rotates by n mod 32. A nonzero n whose residue is zero returns rm unchanged. In every case with nonzero n, the carry equals bit 31 of the result.
- R8: Kind 4 (rotate right by one through carry) returns {carry_in, rm[31:1]} with carry rm[0], whatever the shift distance is.
- R9: Kind codes 5, 6 and 7 pass `rm_val` unchanged with `carry_out` = `carry_in`.
- R10: With REG_OUT=1, operand and carry appear one clock after the inputs; while `rst_n` is low both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (output register variant and assertions) |
| rst_n | input | 1 | Active-low asynchronous reset |
| use_imm | input | 1 | 1 selects the zero-extended immediate as operand |
| imm_val | input | IMM_W (8) | Unsigned immediate constant |
| rm_val | input | DATA_W (32) | Register value to be shifted |
| shift_kind | input | 3 | 0 lsl, 1 lsr, 2 asr, 3 ror, 4 rotate-through-carry, 5..7 pass |
| amt_from_reg | input | 1 | 1 takes the distance from `amt_reg`, 0 from `amt_imm` |
| amt_imm | input | AMT_IMM_W (5) | Immediate shift distance |
| amt_reg | input | AMT_REG_W (8) | Shift distance taken from the low byte of a register |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | DATA_W (32) | Second ALU operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench sweeps every shift kind across every register distance from 0 to 255. It also sweeps every immediate distance on four register patterns, so the boundaries at 0, 1, 31, 32 and 33 are all hit. A unit that sized its shift by 5 bits would wrap a register distance of 33 back to 1. One that clamped the logical shifts wrongly would return a stale carry at exactly 32 instead of rm[0] or rm[31]. One that forgot the rotate modulo would zero the result at 32, 64 and 96. One that let a zero distance reach the carry logic would clobber `carry_in`. Immediate mode is run with hostile register and shift inputs to expose any leak through the mux, and the registered copy is checked for its one-cycle delay and zero reset value.

// File: rtl/opsh_pkg.sv
`timescale 1ns/1ps
package opsh_pkg;
   typedef enum logic [2:0] {
      SH_LSL = 3'd0,
      SH_LSR = 3'd1,
      SH_ASR = 3'd2,
      SH_ROR = 3'd3,
      SH_RRX = 3'd4
   } shift_kind_e;
endpackage

// File: rtl/opsh_amount_sel.sv
`timescale 1ns/1ps
module opsh_amount_sel #(
   parameter int AMT_IMM_W = 5,
   parameter int AMT_REG_W = 8
) (
   input  logic                 from_reg,
   input  logic [AMT_IMM_W-1:0] amt_imm,
   input  logic [AMT_REG_W-1:0] amt_reg,
   output logic [AMT_REG_W-1:0] amt
);
   localparam int PAD_W = AMT_REG_W - AMT_IMM_W;

   always_comb begin
      if (from_reg) amt = amt_reg;
      else          amt = {{PAD_W{1'b0}}, amt_imm};
   end
endmodule

// File: rtl/opsh_core.sv
`timescale 1ns/1ps
module opsh_core
   import opsh_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] rm,
   input  logic [2:0]        kind,
   input  logic [AMT_W-1:0]  amt,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output logic              cout
);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [IDX_W:0]   WFULL  = (IDX_W+1)'(DATA_W);
   localparam logic [AMT_W-1:0] AMT_WD = AMT_W'(DATA_W);

   logic [DATA_W:0]   lsl_x, lsr_x, asr_x;
   logic [AMT_W-1:0]  asr_amt;
   logic [IDX_W-1:0]  rot;
   logic [IDX_W:0]    rot_back;
   logic [DATA_W-1:0] ror_v;
   logic              amt_zero;

   // Extra bit beside the data catches the last bit shifted out.
   assign lsl_x    = {1'b0, rm} << amt;
   assign lsr_x    = {rm, 1'b0} >> amt;
   assign asr_amt  = (amt > AMT_WD) ? AMT_WD : amt;
   assign asr_x    = $unsigned($signed({rm, 1'b0}) >>> asr_amt);
   assign rot      = amt[IDX_W-1:0];
   assign rot_back = WFULL - {1'b0, rot};
   assign ror_v    = (rm >> rot) | (rm << rot_back);
   assign amt_zero = (amt == '0);

   always_comb begin
      res  = rm;
      cout = cin;
      case (kind)
         SH_LSL: if (!amt_zero) begin
            res  = lsl_x[DATA_W-1:0];
            cout = lsl_x[DATA_W];
         end
         SH_LSR: if (!amt_zero) begin
            res  = lsr_x[DATA_W:1];
            cout = lsr_x[0];
         end
         SH_ASR: if (!amt_zero) begin
            res  = asr_x[DATA_W:1];
            cout = asr_x[0];
         end
         SH_ROR: if (!amt_zero) begin
            res  = ror_v;
            cout = ror_v[DATA_W-1];
         end
         SH_RRX: begin
            res  = {cin, rm[DATA_W-1:1]};
            cout = rm[0];
         end
         default: begin
            res  = rm;
            cout = cin;
         end
      endcase
   end

   assert_lsl_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SH_LSL && amt >= AMT_WD) |-> (res == '0));
   assert_lsr_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SH_LSR && !amt_zero) |-> (res[DATA_W-1] == 1'b0));
   assert_asr_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SH_ASR) |-> (res[DATA_W-1] == rm[DATA_W-1]));
   assert_ror_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SH_ROR) |-> ($countones(res) == $countones(rm)));
   assert_ror_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SH_ROR && !amt_zero) |-> (cout == res[DATA_W-1]));
   assert_rrx_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SH_RRX) |-> ($countones({cout, res}) == $countones({cin, rm})));
endmodule

// File: rtl/opsh_outstage.sv
`timescale 1ns/1ps
module opsh_outstage #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] d_op,
   input  logic              d_c,
   output logic [DATA_W-1:0] q_op,
   output logic              q_c
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_op <= '0;
         q_c  <= 1'b0;
      end else begin
         q_op <= d_op;
         q_c  <= d_c;
      end
   end

   assert_reset_zero_R10: assert property (@(posedge clk)
      (!rst_n) |=> (q_op == '0 && q_c == 1'b0) || rst_n);
endmodule

// File: rtl/operand_shifter.sv
`timescale 1ns/1ps
module operand_shifter
   import opsh_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int IMM_W     = 8,
   parameter int AMT_IMM_W = $clog2(DATA_W),
   parameter int AMT_REG_W = 8,
   parameter bit REG_OUT   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 use_imm,
   input  logic [IMM_W-1:0]     imm_val,
   input  logic [DATA_W-1:0]    rm_val,
   input  logic [2:0]           shift_kind,
   input  logic                 amt_from_reg,
   input  logic [AMT_IMM_W-1:0] amt_imm,
   input  logic [AMT_REG_W-1:0] amt_reg,
   input  logic                 carry_in,
   output logic [DATA_W-1:0]    operand_out,
   output logic                 carry_out
);
   localparam int IMM_PAD = DATA_W - IMM_W;

   // Elaboration-time parameter checks
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("operand_shifter: DATA_W must be a power of two, at least 8");
   end
   if (IMM_W < 1 || IMM_W >= DATA_W) begin : g_bad_imm_w
      $error("operand_shifter: IMM_W must lie in 1..DATA_W-1");
   end
   if (AMT_IMM_W != $clog2(DATA_W)) begin : g_bad_amt_imm_w
      $error("operand_shifter: AMT_IMM_W must be clog2(DATA_W)");
   end
   if (AMT_REG_W <= AMT_IMM_W) begin : g_bad_amt_reg_w
      $error("operand_shifter: AMT_REG_W must exceed AMT_IMM_W");
   end

   logic [AMT_REG_W-1:0] amt;
   logic [DATA_W-1:0]    sh_res, op_c;
   logic                 sh_c, c_c;

   opsh_amount_sel #(.AMT_IMM_W(AMT_IMM_W), .AMT_REG_W(AMT_REG_W)) u_amt (
      .from_reg (amt_from_reg),
      .amt_imm  (amt_imm),
      .amt_reg  (amt_reg),
      .amt      (amt)
   );

   opsh_core #(.DATA_W(DATA_W), .AMT_W(AMT_REG_W)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .rm    (rm_val),
      .kind  (shift_kind),
      .amt   (amt),
      .cin   (carry_in),
      .res   (sh_res),
      .cout  (sh_c)
   );

   always_comb begin
      if (use_imm) begin
         op_c = {{IMM_PAD{1'b0}}, imm_val};
         c_c  = carry_in;
      end else begin
         op_c = sh_res;
         c_c  = sh_c;
      end
   end

   if (REG_OUT) begin : g_registered
      opsh_outstage #(.DATA_W(DATA_W)) u_out (
         .clk   (clk),
         .rst_n (rst_n),
         .d_op  (op_c),
         .d_c   (c_c),
         .q_op  (operand_out),
         .q_c   (carry_out)
      );
   end else begin : g_comb
      assign operand_out = op_c;
      assign carry_out   = c_c;
   end

   assert_imm_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      use_imm |-> (c_c == carry_in));
   assert_imm_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      use_imm |-> ((op_c >> IMM_W) == '0));
   assert_zero_amt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!use_imm && shift_kind < 3'd4 && amt == '0) |-> (op_c == rm_val && c_c == carry_in));
   assert_small_amt_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!use_imm && !amt_from_reg && shift_kind == SH_LSL && rm_val[0]) |-> (op_c != '0));
endmodule

// File: tb/tb_operand_shifter.sv
`timescale 1ns/1ps
module tb_operand_shifter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        use_imm = 1'b0;
   logic [7:0]  imm_val = '0;
   logic [31:0] rm_val = '0;
   logic [2:0]  shift_kind = '0;
   logic        amt_from_reg = 1'b0;
   logic [4:0]  amt_imm = '0;
   logic [7:0]  amt_reg = '0;
   logic        carry_in = 1'b0;
   logic [31:0] op_c, op_r;
   logic        c_c, c_r;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   operand_shifter dut (
      .clk(clk), .rst_n(rst_n), .use_imm(use_imm), .imm_val(imm_val),
      .rm_val(rm_val), .shift_kind(shift_kind), .amt_from_reg(amt_from_reg),
      .amt_imm(amt_imm), .amt_reg(amt_reg), .carry_in(carry_in),
      .operand_out(op_c), .carry_out(c_c)
   );

   operand_shifter #(.REG_OUT(1'b1)) dut_reg (
      .clk(clk), .rst_n(rst_n), .use_imm(use_imm), .imm_val(imm_val),
      .rm_val(rm_val), .shift_kind(shift_kind), .amt_from_reg(amt_from_reg),
      .amt_imm(amt_imm), .amt_reg(amt_reg), .carry_in(carry_in),
      .operand_out(op_r), .carry_out(c_r)
   );

   // Bit-serial model: one single-bit step per unit of distance.
   function automatic logic [32:0] model(int kind, int amt, logic [31:0] v, logic c);
      logic [31:0] x = v;
      logic        cy = c;
      if (kind == 4) return {v[0], c, v[31:1]};
      if (kind > 4 || amt == 0) return {c, v};
      case (kind)
         0: for (int i = 0; i < amt; i++) begin cy = x[31]; x = x << 1; end
         1: for (int i = 0; i < amt; i++) begin cy = x[0]; x = x >> 1; end
         2: for (int i = 0; i < amt; i++) begin cy = x[0]; x = {x[31], x[31:1]}; end
         default: begin
            for (int i = 0; i < amt % 32; i++) begin cy = x[0]; x = {x[0], x[31:1]}; end
            if (amt % 32 == 0) cy = x[31];
         end
      endcase
      return {cy, x};
   endfunction

   function automatic string tag_of(int kind, int amt);
      if (kind < 4 && amt == 0) return "R3";
      case (kind)
         0: return "R4";
         1: return "R5";
         2: return "R6";
         3: return "R7";
         4: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] g_op, logic g_c, logic [32:0] exp);
      checks++;
      if ({g_c, g_op} !== exp) begin
         errors++;
         $display("FAIL %s kind=%0d rm=%h amt_imm=%0d amt_reg=%0d src=%0b imm=%0b got=%h/%b exp=%h/%b",
                  tag, shift_kind, rm_val, amt_imm, amt_reg, amt_from_reg, use_imm,
                  g_op, g_c, exp[31:0], exp[32]);
      end
   endtask

   // Drive at negedge, check combinational copy, then registered copy after the edge (R10).
   task automatic apply(string tag, logic [32:0] exp);
      @(negedge clk);
      #0.5;
      check(tag, op_c, c_c, exp);
      @(posedge clk);
      #0.5;
      check({tag, "/R10"}, op_r, c_r, exp);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   logic [31:0] pats [4] = '{32'h8000_0004, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h0000_0001};

   initial begin
      // Reset state of the registered variant (R10)
      rm_val = 32'hFFFF_FFFF; carry_in = 1'b1; shift_kind = 3'd5;
      repeat (3) @(posedge clk);
      #0.5;
      check("R10 reset", op_r, c_r, 33'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // Named examples (R4)
      @(negedge clk);
      use_imm = 0; amt_from_reg = 0; shift_kind = 3'd0;
      rm_val = 32'h8000_0004; amt_imm = 5'd1; carry_in = 1'b0; amt_reg = 8'd200;
      #0.5; check("R4 example lsl1", op_c, c_c, {1'b1, 32'h0000_0008});
      @(negedge clk);
      rm_val = 32'd13; amt_imm = 5'd3;
      #0.5; check("R4 times8", op_c, c_c, {1'b0, 32'd104});

      // Register-sourced distance sweep: all kinds, 0..255 (R2..R9)
      for (int p = 0; p < 4; p++) begin
         for (int k = 0; k < 8; k++) begin
            for (int a = 0; a < 256; a++) begin
               @(negedge clk);
               use_imm = 0; amt_from_reg = 1; shift_kind = 3'(k);
               rm_val = pats[p]; carry_in = p[0]; amt_reg = 8'(a);
               amt_imm = 5'(a + 7);
               apply({"R2 reg ", tag_of(k, a)}, model(k, a, pats[p], p[0]));
            end
         end
      end

      // Immediate-sourced distance sweep: register byte is noise (R2)
      for (int p = 0; p < 4; p++) begin
         for (int k = 0; k < 8; k++) begin
            for (int a = 0; a < 32; a++) begin
               @(negedge clk);
               use_imm = 0; amt_from_reg = 0; shift_kind = 3'(k);
               rm_val = ~pats[p]; carry_in = ~p[0]; amt_imm = 5'(a);
               amt_reg = 8'(255 - a * 3);
               apply({"R2 imm ", tag_of(k, a)}, model(k, a, ~pats[p], ~p[0]));
            end
         end
      end

      // Immediate operand mode with hostile shifter inputs (R1)
      for (int v = 0; v < 256; v++) begin
         @(negedge clk);
         use_imm = 1; imm_val = 8'(v); shift_kind = 3'(v % 8);
         rm_val = {4{8'(v ^ 8'h5A)}}; carry_in = v[1];
         amt_from_reg = v[0]; amt_reg = 8'(v * 7); amt_imm = 5'(v);
         apply("R1 imm", {v[1], 24'h0, 8'(v)});
      end

      finish_run();
   end
endmodule